// File: doc/BRIEF.md
# Harmonic Phase and Interpolated Sine Generator

This block produces the sinusoidal partials for one additive-synthesis voice. A wrapping base phase register steps forward by a per-voice increment on every audio sample tick. For that sample it emits, one per clock, the sine value of harmonics 1 through 64. The phase of harmonic k is k times the captured base phase, truncated to the phase width. Each output carries its harmonic number and a valid strobe. Amplitude weighting and summation are done by downstream blocks.

A shared 1024-entry signed sine table is addressed by the top phase bits. The eight bits below the index set a linear blend between the addressed entry and the next one. The table wraps at its end. The pipeline latency is fixed, so a consumer can line its per-harmonic data up with the index tag.

Top module: `harmonic_sine_gen`

## Requirements
- R1: After reset, out_valid is 0 and out_harm and out_sample read 0. The base phase starts at 0, so the first sample's 64 outputs are all 0.
- R2: An accepted tick captures the current base phase as the phase of that sample. It then adds base_inc to the base phase, modulo 2^32.
- R3: Harmonic k of a sample uses phase (k * captured phase) mod 2^32.
- R4: Each accepted tick yields exactly 64 valid outputs on consecutive clocks, with out_harm counting 1, 2, ... 64. out_harm stays in the range 1..64 whenever out_valid is high.
- R5: Harmonic 1 is valid in the cycle that follows the third rising edge, counting the edge that accepts the tick as the first.
- R6: The table index is phase bits [31:22]. Entry i holds round(32767 * sin(2*pi*i/1024)), rounded half away from zero.
- R7: The fraction f is phase bits [21:14]. The output is a + floor((b - a) * f / 256), where a is entry[index] and b is entry[index+1].
- R8: When the index is 1023, the entry b is taken from entry 0.
- R9: A tick while harmonics 1..63 are being issued is ignored. The sequence does not restart, no extra outputs appear, and the base phase does not change.
- R10: A tick in the cycle that issues harmonic 64 is accepted. Harmonic 1 of the new sample then follows harmonic 64 with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Audio sample tick; starts a 64-harmonic sequence |
| base_inc | input | 32 | Base phase increment per sample (unsigned fraction of a cycle) |
| out_valid | output | 1 | Output sample is valid |
| out_harm | output | 7 | Harmonic number of the output, 1..64 |
| out_sample | output | 16 | Interpolated signed sine value |

## Verification
Two events can fall in the same cycle: the issue of harmonic 64 and the acceptance of the next tick. The bench raises a tick exactly on that cycle and checks that harmonic 64 of the old sample and harmonic 1 of the new one come out on adjacent clocks. Both must carry the values the scoreboard predicts. The bench also raises a tick in the middle of a sequence. It then checks that no extra outputs appear and that the next sample's phases show an unchanged base accumulator.

// File: rtl/harmonic_sine_gen.sv
module harmonic_sine_gen #(
  parameter int PHASE_W   = 32,
  parameter int NUM_HARM  = 64,
  parameter int TBL_BITS  = 10,
  parameter int FRAC_BITS = 8,
  parameter int SAMP_W    = 16,
  localparam int HW       = $clog2(NUM_HARM + 1),
  localparam int TBL_N    = 1 << TBL_BITS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick,
  input  logic [PHASE_W-1:0]       base_inc,
  output logic                     out_valid,
  output logic [HW-1:0]            out_harm,
  output logic signed [SAMP_W-1:0] out_sample
);

  localparam real PI = 3.14159265358979323846;

  function automatic int sine_entry(int i);
    real v;
    v = (2.0 ** (SAMP_W - 1) - 1.0) * $sin(2.0 * PI * real'(i) / real'(TBL_N));
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  logic signed [SAMP_W-1:0] lut [TBL_N];
  for (genvar i = 0; i < TBL_N; i++) begin : g_lut
    localparam int E = sine_entry(i);
    assign lut[i] = SAMP_W'(E);
  end

  logic [PHASE_W-1:0] acc, snap, ph;
  logic [HW-1:0]      cnt;
  logic               accept;

  assign accept = tick && (cnt == '0 || cnt == HW'(NUM_HARM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      snap <= '0;
      ph   <= '0;
      cnt  <= '0;
    end else begin
      if (accept) begin
        acc  <= acc + base_inc;
        snap <= acc;
        ph   <= acc;
        cnt  <= HW'(1);
      end else begin
        ph <= ph + snap;
        if (cnt == HW'(NUM_HARM)) cnt <= '0;
        else if (cnt != '0)       cnt <= cnt + HW'(1);
      end
    end
  end

  logic [TBL_BITS-1:0]  idx;
  logic [FRAC_BITS-1:0] frac;
  assign idx  = ph[PHASE_W-1 -: TBL_BITS];
  assign frac = ph[PHASE_W-TBL_BITS-1 -: FRAC_BITS];

  logic signed [SAMP_W-1:0] s2_a, s2_b;
  logic [FRAC_BITS-1:0]     s2_f;
  logic [HW-1:0]            s2_k;
  logic                     s2_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_a <= '0;
      s2_b <= '0;
      s2_f <= '0;
      s2_k <= '0;
      s2_v <= 1'b0;
    end else begin
      s2_a <= lut[idx];
      s2_b <= lut[idx + TBL_BITS'(1)];
      s2_f <= frac;
      s2_k <= cnt;
      s2_v <= (cnt != '0);
    end
  end

  logic signed [SAMP_W:0]             diff;
  logic signed [SAMP_W+FRAC_BITS+1:0] prod;
  logic signed [SAMP_W-1:0]           interp;
  assign diff   = {s2_b[SAMP_W-1], s2_b} - {s2_a[SAMP_W-1], s2_a};
  assign prod   = diff * $signed({1'b0, s2_f});
  assign interp = s2_a + SAMP_W'(prod >>> FRAC_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_harm   <= '0;
      out_sample <= '0;
    end else begin
      out_valid  <= s2_v;
      out_harm   <= s2_v ? s2_k : '0;
      out_sample <= s2_v ? interp : '0;
    end
  end

endmodule

// File: rtl/harmonic_sine_gen_checks.sv
module harmonic_sine_gen_checks #(
  parameter int PHASE_W  = 32,
  parameter int NUM_HARM = 64,
  parameter int HW       = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               tick,
  input logic [PHASE_W-1:0] base_inc,
  input logic [PHASE_W-1:0] acc,
  input logic [HW-1:0]      cnt,
  input logic               out_valid,
  input logic [HW-1:0]      out_harm
);

  logic accept;
  assign accept = tick && (cnt == '0 || cnt == HW'(NUM_HARM));

  assert_acc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> acc == $past(acc) + $past(base_inc));

  assert_acc_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(acc));

  assert_harm_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_harm >= HW'(1) && out_harm <= HW'(NUM_HARM)));

  assert_harm_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_harm != HW'(NUM_HARM)) |=> (out_valid && out_harm == $past(out_harm) + HW'(1)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(accept, 3) |-> (out_valid && out_harm == HW'(1)));

  assert_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_harm == HW'(NUM_HARM) && $past(accept, 2)) |=> (out_valid && out_harm == HW'(1)));

endmodule

bind harmonic_sine_gen harmonic_sine_gen_checks #(
  .PHASE_W(PHASE_W), .NUM_HARM(NUM_HARM), .HW(HW)
) u_checks (
  .clk(clk), .rst_n(rst_n), .tick(tick), .base_inc(base_inc),
  .acc(acc), .cnt(cnt), .out_valid(out_valid), .out_harm(out_harm)
);

// File: tb/tb_harmonic_sine_gen.sv
module tb_harmonic_sine_gen;

  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [31:0] base_inc = '0;
  logic        out_valid;
  logic [6:0]  out_harm;
  logic signed [15:0] out_sample;

  harmonic_sine_gen dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .base_inc(base_inc),
    .out_valid(out_valid), .out_harm(out_harm), .out_sample(out_sample)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] exp_acc = '0;
  int q_harm[$];
  int q_val[$];

  function automatic int tbl(int i);
    real v;
    v = 32767.0 * $sin(2.0 * PI * real'(i) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int model(logic [31:0] ph);
    int i, f, a, b, p;
    i = int'(ph[31:22]);
    f = int'(ph[21:14]);
    a = tbl(i);
    b = tbl((i + 1) % 1024);
    p = (b - a) * f;
    return a + (p >>> 8);
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic start_sample(logic [31:0] inc);
    @(negedge clk);
    tick = 1'b1;
    base_inc = inc;
    for (int k = 1; k <= 64; k++) begin
      logic [31:0] ph;
      ph = exp_acc * 32'(k);
      q_harm.push_back(k);
      q_val.push_back(model(ph));
    end
    exp_acc = exp_acc + inc;
    @(negedge clk);
    tick = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q_harm.size() == 0) begin
        check(1'b0, "R4/R9 unexpected output", int'(out_harm), 0);
      end else begin
        int eh, ev;
        eh = q_harm.pop_front();
        ev = q_val.pop_front();
        check(int'(out_harm) == eh, "R4 harmonic tag", int'(out_harm), eh);
        check(int'(out_sample) == ev, "R3/R6/R7/R8 sample value", int'(out_sample), ev);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(out_harm == '0, "R1 out_harm after reset", int'(out_harm), 0);
    check(out_sample == '0, "R1 out_sample after reset", int'(out_sample), 0);

    // R1/R5: first sample uses phase 0; latency of harmonic 1
    start_sample(32'h0123_4567);
    check(out_valid == 1'b0, "R5 not valid after 1st edge", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b0, "R5 not valid after 2nd edge", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid && out_harm == 7'd1, "R5 harmonic 1 after 3rd edge", int'(out_harm), 1);
    repeat (70) @(negedge clk);

    // R2/R3: sample at 0x01234567, next captures 0xFFFFF000
    start_sample(32'hFEDC_AA99);
    repeat (70) @(negedge clk);

    // R8: index 1023 wraps to entry 0 (low harmonics)
    check(model(32'hFFFF_F000) == tbl(1023) + (((tbl(0) - tbl(1023)) * 255) >>> 8),
          "R8 bench wrap model", model(32'hFFFF_F000), tbl(1023));
    start_sample(32'h0800_0000);
    // R10: tick on the cycle that issues harmonic 64
    repeat (62) @(negedge clk);
    start_sample(32'h0055_5555);
    @(negedge clk);
    check(out_valid && out_harm == 7'd64, "R10 harmonic 64 of old sample", int'(out_harm), 64);
    @(negedge clk);
    check(out_valid && out_harm == 7'd1, "R10 harmonic 1 follows with no gap", int'(out_harm), 1);

    // R9: tick mid-sequence is ignored
    repeat (10) @(negedge clk);
    tick = 1'b1;
    base_inc = 32'h1234_5678;
    @(negedge clk);
    tick = 1'b0;
    repeat (70) @(negedge clk);
    start_sample(32'h0000_0400);
    repeat (80) @(negedge clk);

    check(q_harm.size() == 0, "R4/R9 all expected outputs seen", q_harm.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule